// File: doc/BRIEF.md
# CompactFlash True IDE Multiword DMA Engine

This block is a single-channel bus-master DMA engine that moves 16-bit words between a CompactFlash card running in True IDE mode and a word-addressed memory port. Software programs a start address, a timing register and a configuration register that holds the word count, the direction, a byte-swap flag and the policy for gaps in the device's DMA request. It then enables the engine and waits for the done status or the interrupt. Scatter-gather chaining is left to software. Software restarts the engine once for each buffer.

On the card side the engine raises the acknowledge, produces read or write strobes with programmable asserted and negated widths, and captures or drives the 16-bit data bus. On the memory side it issues one request at a time and holds each request until it is acknowledged. The word count is held in minus-one form and counts down. A transfer that runs to the end leaves the count reading all ones. A transfer that ends early leaves the number of remaining words minus one. When the device drops its request, the engine either pauses until the request returns or ends the transfer, depending on a configuration flag.

Top module: `cfdma_engine`

## Requirements
- R1: After reset the engine is idle with `dmack`=0, `dior_n`=1, `diow_n`=1 and `irq`=0. The config register (CSR address 0) reads 0x00FFFFF0. Its fields are: bit 0 enable, bit 1 direction, bit 2 stop-on-drop, bit 3 swap, and bits 23:4 the 20-bit size.
- R2: With direction 0 (card to memory), each word captured during a `dior_n` strobe is written to memory. The first word goes to the start address (CSR address 1), and each completed word advances the address by one.
- R3: With direction 1 (memory to card), each word is read from memory at consecutive addresses. It is then driven on `ata_dout` with `ata_doe` high while `diow_n` pulses low.
- R4: A transfer of size N-1 moves exactly N words. After the last word the enable bit reads 0, the size field reads 0xFFFFF, and done (bit 0 of CSR address 3) reads 1.
- R5: Writing 1 to done clears it. Writing 0 to it leaves it unchanged.
- R6: `irq` is high only when done is 1 and the interrupt-enable bit (bit 0 of CSR address 4) is 1.
- R7: With swap set, the high and low bytes of every word are exchanged between the card bus and memory, in both directions.
- R8: With stop-on-drop 0, dropping `dmarq` in the middle of a transfer only pauses it. No strobe occurs and `dmack` falls while the request is low. The transfer resumes when the request returns and completes the full count.
- R9: With stop-on-drop 1, dropping `dmarq` in the middle of a transfer ends it. Done sets, enable clears, and the size field reads the number of words not moved, minus one.
- R10: The strobe low time is (field+1) x multiplier clocks. The multiplier is set by timing bits 1:0 (0 gives 4x, 1 gives 1x, 2 gives 2x, 3 gives 8x). The read strobe width is set by bits 5:2 and the write strobe width by bits 13:10.
- R11: `dmarq` must be seen high, after a two-flop synchronizer, for the unscaled count in timing bits 31:28 before a new strobe sequence starts.
- R12: Writing the config register with enable 0 and size 0xFFFFF stops the engine at once. The strobe and `dmack` go high-inactive, and done does not set.
- R13: `dmack` is high whenever either strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_we | input | 1 | CSR write strobe |
| csr_re | input | 1 | CSR read strobe (data valid next cycle) |
| csr_addr | input | 3 | CSR select: 0 config, 1 address, 2 timing, 3 status, 4 interrupt enable |
| csr_wdata | input | 32 | CSR write data |
| csr_rdata | output | 32 | CSR read data (registered) |
| irq | output | 1 | Interrupt: done gated by enable |
| mem_req | output | 1 | Memory request, held until `mem_ack` |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | ADDR_W | Word address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid with `mem_ack` |
| mem_ack | input | 1 | Memory acknowledge |
| dmarq | input | 1 | Device DMA request (asynchronous) |
| dmack | output | 1 | DMA acknowledge to the device |
| dior_n | output | 1 | Read strobe, active low |
| diow_n | output | 1 | Write strobe, active low |
| ata_din | input | 16 | Data from the card bus |
| ata_dout | output | 16 | Data to the card bus |
| ata_doe | output | 1 | Card-bus output enable |

## Verification
Four patterns exercise the main function:
- Plain card-to-memory runs check word order and address stepping.
- Memory-to-card runs with swap set show whether the byte exchange sits on the correct side of the data path.
- Card-to-memory runs with swap set confirm the exchange in the other direction.
- Runs in which the request drops partway through separate the pause policy from the stop policy: the pause run must deliver every word, while the stop run must leave a residual count equal to the untransferred words minus one.

Scaled strobe widths and an oversized request-qualification count show whether timing fields are scaled or left raw. An abort issued during a long strobe shows whether the stop write overrides a phase that is still in progress.

// File: rtl/cfdma_pkg.sv
package cfdma_pkg;

  localparam int CSR_W = 32;

  localparam logic [2:0] ADR_CFG  = 3'd0;
  localparam logic [2:0] ADR_BASE = 3'd1;
  localparam logic [2:0] ADR_TIM  = 3'd2;
  localparam logic [2:0] ADR_STAT = 3'd3;
  localparam logic [2:0] ADR_IEN  = 3'd4;

  // Timing register layout, MSB first
  typedef struct packed {
    logic [3:0] rq_qual;
    logic [3:0] pause;
    logic [2:0] ack_hold;
    logic [2:0] ack_setup;
    logic [3:0] wr_neg;
    logic [3:0] wr_act;
    logic [3:0] rd_neg;
    logic [3:0] rd_act;
    logic [1:0] mult;
  } timing_t;

  typedef enum logic [3:0] {
    S_IDLE, S_WAIT_RQ, S_MEM_RD, S_SETUP, S_STROBE,
    S_RECOVER, S_MEM_WR, S_HOLD, S_PAUSE
  } seq_state_e;

  // Counter preload for a phase of (f+1)*multiplier clocks
  function automatic logic [7:0] phase_load(input logic [3:0] f, input logic [1:0] enc);
    logic [7:0] m;
    logic [7:0] p;
    case (enc)
      2'd0:    m = 8'd4;
      2'd1:    m = 8'd1;
      2'd2:    m = 8'd2;
      default: m = 8'd8;
    endcase
    p = (8'(f) + 8'd1) * m;
    return p - 8'd1;
  endfunction

  function automatic logic [15:0] byte_exchange(input logic [15:0] w, input logic en);
    return en ? {w[7:0], w[15:8]} : w;
  endfunction

endpackage

// File: rtl/cfdma_regs.sv
module cfdma_regs
  import cfdma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SIZE_W = 20
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                csr_we,
  input  logic                csr_re,
  input  logic [2:0]          csr_addr,
  input  logic [CSR_W-1:0]    csr_wdata,
  output logic [CSR_W-1:0]    csr_rdata,
  input  logic                word_done,
  input  logic                finish,
  output logic                run,
  output logic                dir,
  output logic                stop_on_drop,
  output logic                swap,
  output timing_t             tim,
  output logic [ADDR_W-1:0]   cur_addr,
  output logic                last_word,
  output logic                irq
);

  localparam int SIZE_LSB = 4;

  logic              en_q, dir_q, stop_q, swap_q, done_q, ien_q, irq_q;
  logic [SIZE_W-1:0] size_q;
  logic [ADDR_W-1:0] addr_q;
  timing_t           tim_q;
  logic [CSR_W-1:0]  rd_mux;

  wire cfg_wr  = csr_we && (csr_addr == ADR_CFG);
  wire base_wr = csr_we && (csr_addr == ADR_BASE);
  wire tim_wr  = csr_we && (csr_addr == ADR_TIM);
  wire stat_wr = csr_we && (csr_addr == ADR_STAT);
  wire ien_wr  = csr_we && (csr_addr == ADR_IEN);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      dir_q  <= 1'b0;
      stop_q <= 1'b0;
      swap_q <= 1'b0;
      size_q <= '1;
    end else if (cfg_wr) begin
      en_q   <= csr_wdata[0];
      dir_q  <= csr_wdata[1];
      stop_q <= csr_wdata[2];
      swap_q <= csr_wdata[3];
      size_q <= csr_wdata[SIZE_LSB +: SIZE_W];
    end else begin
      if (word_done) size_q <= size_q - 1'b1;
      if (finish)    en_q   <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      tim_q  <= '0;
      done_q <= 1'b0;
      ien_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (base_wr)        addr_q <= csr_wdata[ADDR_W-1:0];
      else if (word_done) addr_q <= addr_q + 1'b1;
      if (tim_wr) tim_q <= timing_t'(csr_wdata);
      if (finish)                       done_q <= 1'b1;
      else if (stat_wr && csr_wdata[0]) done_q <= 1'b0;
      if (ien_wr) ien_q <= csr_wdata[0];
      irq_q <= done_q & ien_q;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (csr_addr)
      ADR_CFG: begin
        rd_mux[0] = en_q;
        rd_mux[1] = dir_q;
        rd_mux[2] = stop_q;
        rd_mux[3] = swap_q;
        rd_mux[SIZE_LSB +: SIZE_W] = size_q;
      end
      ADR_BASE: rd_mux[ADDR_W-1:0] = addr_q;
      ADR_TIM:  rd_mux = CSR_W'(tim_q);
      ADR_STAT: rd_mux[0] = done_q;
      ADR_IEN:  rd_mux[0] = ien_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         csr_rdata <= '0;
    else if (csr_re) csr_rdata <= rd_mux;
  end

  assign run          = en_q;
  assign dir          = dir_q;
  assign stop_on_drop = stop_q;
  assign swap         = swap_q;
  assign tim          = tim_q;
  assign cur_addr     = addr_q;
  assign last_word    = (size_q == '0);
  assign irq          = irq_q;

  a_r4_finish_sets_done: assert property (@(posedge clk) disable iff (rst)
    (finish && !cfg_wr) |=> (done_q && !en_q));

  a_r2_addr_advance: assert property (@(posedge clk) disable iff (rst)
    (word_done && !base_wr) |=> (addr_q == $past(addr_q) + 1'b1));

  a_r6_irq_gated: assert property (@(posedge clk) disable iff (rst)
    !ien_q |=> !irq_q);

  a_r5_done_sticky: assert property (@(posedge clk) disable iff (rst)
    (done_q && !(stat_wr && csr_wdata[0])) |=> done_q);

endmodule

// File: rtl/cfdma_rq_qual.sv
module cfdma_rq_qual #(
  parameter int RQ_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            dmarq_async,
  input  logic [RQ_W-1:0] limit,
  output logic            qualified
);

  logic [1:0]      sync_q;
  logic [RQ_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= 2'b00;
      cnt_q  <= '0;
    end else begin
      sync_q <= {sync_q[0], dmarq_async};
      if (!sync_q[1])          cnt_q <= '0;
      else if (cnt_q != limit) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign qualified = sync_q[1] && (cnt_q == limit);

  a_r11_needs_history: assert property (@(posedge clk) disable iff (rst)
    (qualified && (limit != '0)) |-> $past(sync_q[1]));

endmodule

// File: rtl/cfdma_seq.sv
module cfdma_seq
  import cfdma_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              dir,
  input  logic              stop_on_drop,
  input  logic              swap,
  input  timing_t           tim,
  input  logic              last_word,
  input  logic              rq_ok,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [DATA_W-1:0] ata_din,
  output logic              mem_req,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              dmack,
  output logic              dior_n,
  output logic              diow_n,
  output logic [DATA_W-1:0] ata_dout,
  output logic              ata_doe,
  output logic              word_done,
  output logic              finish
);

  seq_state_e        state_q, state_d;
  logic              term_q, term_d;
  logic [7:0]        cnt_q, load_v;
  logic              tdone, advance;
  logic [DATA_W-1:0] cap_q;

  assign tdone = (cnt_q == 8'd0);

  always_comb begin
    state_d   = state_q;
    term_d    = term_q;
    word_done = 1'b0;
    finish    = 1'b0;
    advance   = 1'b0;
    case (state_q)
      S_IDLE:    if (run) begin state_d = S_WAIT_RQ; term_d = 1'b0; end
      S_WAIT_RQ: if (rq_ok) state_d = dir ? S_MEM_RD : S_SETUP;
      S_MEM_RD:  if (mem_ack) state_d = S_SETUP;
      S_SETUP:   if (tdone) state_d = S_STROBE;
      S_STROBE:  if (tdone) state_d = S_RECOVER;
      S_RECOVER: if (tdone) begin
                   if (dir) advance = 1'b1;
                   else     state_d = S_MEM_WR;
                 end
      S_MEM_WR:  if (mem_ack) advance = 1'b1;
      S_HOLD:    if (tdone) state_d = S_PAUSE;
      S_PAUSE:   if (tdone) begin
                   if (term_q) begin finish = 1'b1; state_d = S_IDLE; end
                   else state_d = S_WAIT_RQ;
                 end
      default:   state_d = S_IDLE;
    endcase
    if (advance) begin
      word_done = 1'b1;
      if (last_word) begin
        state_d = S_HOLD;
        term_d  = 1'b1;
      end else if (rq_ok) begin
        state_d = dir ? S_MEM_RD : S_STROBE;
      end else begin
        state_d = S_HOLD;
        term_d  = stop_on_drop;
      end
    end
    if (!run && state_q != S_IDLE) begin
      state_d   = S_IDLE;
      word_done = 1'b0;
      finish    = 1'b0;
    end
  end

  always_comb begin
    case (state_d)
      S_SETUP:   load_v = phase_load({1'b0, tim.ack_setup}, tim.mult);
      S_STROBE:  load_v = phase_load(dir ? tim.wr_act : tim.rd_act, tim.mult);
      S_RECOVER: load_v = phase_load(dir ? tim.wr_neg : tim.rd_neg, tim.mult);
      S_HOLD:    load_v = phase_load({1'b0, tim.ack_hold}, tim.mult);
      S_PAUSE:   load_v = phase_load(tim.pause, tim.mult);
      default:   load_v = 8'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      term_q  <= 1'b0;
      cnt_q   <= 8'd0;
    end else begin
      state_q <= state_d;
      term_q  <= term_d;
      if (state_d != state_q) cnt_q <= load_v;
      else if (!tdone)        cnt_q <= cnt_q - 8'd1;
    end
  end

  // Registered bus-side outputs follow the next state
  always_ff @(posedge clk) begin
    if (rst) begin
      dmack   <= 1'b0;
      dior_n  <= 1'b1;
      diow_n  <= 1'b1;
      ata_doe <= 1'b0;
      mem_req <= 1'b0;
      mem_we  <= 1'b0;
    end else begin
      dmack   <= (state_d == S_SETUP) || (state_d == S_STROBE) || (state_d == S_RECOVER) ||
                 (state_d == S_MEM_WR) || (state_d == S_HOLD);
      dior_n  <= !((state_d == S_STROBE) && !dir);
      diow_n  <= !((state_d == S_STROBE) && dir);
      ata_doe <= dir && ((state_d == S_SETUP) || (state_d == S_STROBE) || (state_d == S_RECOVER));
      mem_req <= (state_d == S_MEM_RD) || (state_d == S_MEM_WR);
      mem_we  <= (state_d == S_MEM_WR);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_q    <= '0;
      ata_dout <= '0;
    end else begin
      if (state_q == S_STROBE && tdone && !dir) cap_q <= byte_exchange(ata_din, swap);
      if (state_q == S_MEM_RD && mem_ack)       ata_dout <= byte_exchange(mem_rdata, swap);
    end
  end

  assign mem_wdata = cap_q;

  a_r13_ack_covers_strobe: assert property (@(posedge clk) disable iff (rst)
    (!dior_n || !diow_n) |-> dmack);

  a_r3_single_strobe: assert property (@(posedge clk) disable iff (rst)
    !(!dior_n && !diow_n));

  a_r3_drive_during_write: assert property (@(posedge clk) disable iff (rst)
    !diow_n |-> ata_doe);

  a_r8_wait_for_request: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_WAIT_RQ && !rq_ok) |=> (state_q != S_SETUP && state_q != S_MEM_RD));

  a_r12_halt_quiet: assert property (@(posedge clk) disable iff (rst)
    (!run && state_q != S_IDLE) |=> (!dmack ##1 (dior_n && diow_n && !dmack)));

endmodule

// File: rtl/cfdma_engine.sv
module cfdma_engine
  import cfdma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SIZE_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csr_we,
  input  logic              csr_re,
  input  logic [2:0]        csr_addr,
  input  logic [31:0]       csr_wdata,
  output logic [31:0]       csr_rdata,
  output logic              irq,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [15:0]       mem_wdata,
  input  logic [15:0]       mem_rdata,
  input  logic              mem_ack,
  input  logic              dmarq,
  output logic              dmack,
  output logic              dior_n,
  output logic              diow_n,
  input  logic [15:0]       ata_din,
  output logic [15:0]       ata_dout,
  output logic              ata_doe
);

  localparam int DATA_W = 16;
  localparam int RQ_W   = 4;

  logic    run, dir, stop_on_drop, swap, last_word, rq_ok, word_done, finish;
  timing_t tim;

  cfdma_regs #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_regs (
    .clk(clk), .rst(rst),
    .csr_we(csr_we), .csr_re(csr_re), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .word_done(word_done), .finish(finish),
    .run(run), .dir(dir), .stop_on_drop(stop_on_drop), .swap(swap),
    .tim(tim), .cur_addr(mem_addr), .last_word(last_word), .irq(irq)
  );

  cfdma_rq_qual #(.RQ_W(RQ_W)) u_rq (
    .clk(clk), .rst(rst), .dmarq_async(dmarq),
    .limit(tim.rq_qual), .qualified(rq_ok)
  );

  cfdma_seq #(.DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst(rst),
    .run(run), .dir(dir), .stop_on_drop(stop_on_drop), .swap(swap),
    .tim(tim), .last_word(last_word), .rq_ok(rq_ok),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .ata_din(ata_din),
    .mem_req(mem_req), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .dmack(dmack), .dior_n(dior_n), .diow_n(diow_n),
    .ata_dout(ata_dout), .ata_doe(ata_doe),
    .word_done(word_done), .finish(finish)
  );

endmodule

// File: tb/cfdma_engine_test.sv
module cfdma_engine_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        csr_we = 1'b0, csr_re = 1'b0;
  logic [2:0]  csr_addr = 3'd0;
  logic [31:0] csr_wdata = 32'd0;
  logic [31:0] csr_rdata;
  logic        irq, mem_req, mem_we, mem_ack, dmack, dior_n, diow_n, ata_doe;
  logic [15:0] mem_addr, mem_wdata, mem_rdata, ata_din, ata_dout;
  logic        dmarq = 1'b0;

  always #10 clk = ~clk;

  cfdma_engine uut (
    .clk(clk), .rst(rst), .csr_we(csr_we), .csr_re(csr_re), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .irq(irq),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .dmarq(dmarq), .dmack(dmack),
    .dior_n(dior_n), .diow_n(diow_n), .ata_din(ata_din), .ata_dout(ata_dout),
    .ata_doe(ata_doe)
  );

  int n_checks = 0, n_err = 0;
  string cur_tag = "R2";

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Memory model
  logic [15:0] mem [0:255];
  assign mem_rdata = mem[mem_addr[7:0]];
  always @(posedge clk) begin
    if (rst) mem_ack <= 1'b0;
    else begin
      mem_ack <= mem_req && !mem_ack;
      if (mem_req && mem_ack && mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    end
  end

  // Device model
  int rd_idx = 0;
  function automatic logic [15:0] dev_word(input int i);
    return {8'(i) ^ 8'hC3, 8'(i) + 8'h11};
  endfunction
  assign ata_din = dev_word(rd_idx);

  function automatic logic [15:0] bswap(input logic [15:0] w);
    return {w[7:0], w[15:8]};
  endfunction

  // Scoreboard
  typedef struct { logic [15:0] a; logic [15:0] d; } mexp_t;
  mexp_t       mq[$];
  logic [15:0] dq[$];
  int mw_cnt = 0;
  int rcnt = 0, wcnt = 0, last_rw = 0, last_ww = 0;
  logic prev_r = 1'b1, prev_w = 1'b1;

  always @(negedge clk) begin
    if (!rst && mem_req && mem_we && mem_ack) begin
      mw_cnt++;
      if (mq.size() == 0) check(1'b0, {cur_tag, " unexpected memory write"}, {16'h0, mem_addr}, 32'h0);
      else begin
        mexp_t e;
        e = mq.pop_front();
        check(mem_addr == e.a, {cur_tag, " memory address"}, {16'h0, mem_addr}, {16'h0, e.a});
        check(mem_wdata == e.d, {cur_tag, " memory data"}, {16'h0, mem_wdata}, {16'h0, e.d});
      end
    end
    if (!rst && prev_w == 1'b0 && diow_n == 1'b1) begin
      if (dq.size() == 0) check(1'b0, {cur_tag, " unexpected device write"}, {16'h0, ata_dout}, 32'h0);
      else begin
        logic [15:0] d;
        d = dq.pop_front();
        check(ata_dout == d, {cur_tag, " device data"}, {16'h0, ata_dout}, {16'h0, d});
      end
    end
    if (!dior_n) rcnt++;
    else if (prev_r == 1'b0) begin last_rw = rcnt; rcnt = 0; rd_idx++; end
    if (!diow_n) wcnt++;
    else if (prev_w == 1'b0) begin last_ww = wcnt; wcnt = 0; end
    prev_r = dior_n;
    prev_w = diow_n;
  end

  task automatic csr_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    csr_we = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic csr_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    csr_re = 1'b1; csr_addr = a;
    @(negedge clk);
    csr_re = 1'b0;
    d = csr_rdata;
  endtask

  function automatic logic [31:0] cfg_word(input bit en, input bit dir, input bit stp, input bit sw, input logic [19:0] sz);
    return {8'h00, sz, sw, stp, dir, en};
  endfunction

  function automatic logic [31:0] tim_word(input logic [1:0] m, input logic [3:0] ra, input logic [3:0] rn,
                                           input logic [3:0] wa, input logic [3:0] wn, input logic [2:0] as,
                                           input logic [2:0] ah, input logic [3:0] pz, input logic [3:0] rq);
    return {rq, pz, ah, as, wn, wa, rn, ra, m};
  endfunction

  task automatic wait_done(output bit ok);
    logic [31:0] v;
    ok = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      csr_read(3'd3, v);
      if (v[0]) begin ok = 1'b1; break; end
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic push_reads(input int n, input logic [15:0] base, input int idx0, input bit sw);
    for (int i = 0; i < n; i++) begin
      mexp_t e;
      e.a = base + 16'(i);
      e.d = sw ? bswap(dev_word(idx0 + i)) : dev_word(idx0 + i);
      mq.push_back(e);
    end
  endtask

  bit finished = 1'b0;
  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_err++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
    finish_run();
  end

  initial begin
    logic [31:0] v;
    bit ok;
    int start, k, dly;
    for (int i = 0; i < 256; i++) mem[i] = 16'(i * 16'h0135 + 16'h1234);
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check(dmack == 1'b0 && dior_n && diow_n && !irq, "R1 idle pins", {28'h0, dmack, dior_n, diow_n, irq}, 32'h6);
    csr_read(3'd0, v);
    check(v == 32'h00FFFFF0, "R1 config reset", v, 32'h00FFFFF0);

    // R2/R4 plain card-to-memory transfer
    cur_tag = "R2";
    csr_write(3'd2, tim_word(2'd1, 4'd1, 4'd1, 4'd2, 4'd1, 3'd0, 3'd0, 4'd0, 4'd2));
    csr_write(3'd1, 32'h10);
    push_reads(4, 16'h10, rd_idx, 1'b0);
    dmarq = 1'b1;
    csr_write(3'd0, cfg_word(1, 0, 0, 0, 20'd3));
    wait_done(ok);
    check(ok, "R4 done after read", {31'h0, ok}, 32'h1);
    csr_read(3'd0, v);
    check(v == 32'h00FFFFF0, "R4 size all ones and enable clear", v, 32'h00FFFFF0);
    csr_read(3'd1, v);
    check(v == 32'h14, "R2 address advanced per word", v, 32'h14);
    check(mq.size() == 0, "R2 all words delivered", mq.size(), 32'h0);
    check(irq == 1'b0, "R6 irq masked when disabled", {31'h0, irq}, 32'h0);

    // R5 done write-one-to-clear
    csr_write(3'd3, 32'h0);
    csr_read(3'd3, v);
    check(v[0] == 1'b1, "R5 writing 0 keeps done", v, 32'h1);
    csr_write(3'd3, 32'h1);
    csr_read(3'd3, v);
    check(v[0] == 1'b0, "R5 writing 1 clears done", v, 32'h0);

    // R3/R7/R6 memory-to-card with swap and interrupt
    cur_tag = "R3";
    csr_write(3'd4, 32'h1);
    for (int i = 0; i < 3; i++) dq.push_back(bswap(mem[8'h40 + i]));
    csr_write(3'd1, 32'h40);
    csr_write(3'd0, cfg_word(1, 1, 0, 1, 20'd2));
    wait_done(ok);
    check(ok, "R3 done after write", {31'h0, ok}, 32'h1);
    check(dq.size() == 0, "R7 swapped words written to card", dq.size(), 32'h0);
    check(last_ww == 3, "R10 write strobe width 1x", last_ww, 32'd3);
    repeat (2) @(negedge clk);
    check(irq == 1'b1, "R6 irq with done and enable", {31'h0, irq}, 32'h1);
    csr_write(3'd3, 32'h1);
    repeat (2) @(negedge clk);
    check(irq == 1'b0, "R6 irq drops with done", {31'h0, irq}, 32'h0);
    csr_write(3'd4, 32'h0);

    // R7 card-to-memory with swap
    cur_tag = "R7";
    csr_write(3'd1, 32'h60);
    push_reads(3, 16'h60, rd_idx, 1'b1);
    csr_write(3'd0, cfg_word(1, 0, 0, 1, 20'd2));
    wait_done(ok);
    check(ok && mq.size() == 0, "R7 swapped words to memory", mq.size(), 32'h0);
    csr_write(3'd3, 32'h1);

    // R8 pause on request drop
    cur_tag = "R8";
    csr_write(3'd1, 32'h80);
    push_reads(6, 16'h80, rd_idx, 1'b0);
    start = mw_cnt;
    csr_write(3'd0, cfg_word(1, 0, 0, 0, 20'd5));
    while (mw_cnt < start + 2) @(negedge clk);
    dmarq = 1'b0;
    repeat (20) @(negedge clk);
    k = mw_cnt;
    repeat (80) @(negedge clk);
    check(mw_cnt == k, "R8 no transfer while request low", mw_cnt, k);
    check(dmack == 1'b0, "R8 acknowledge dropped during pause", {31'h0, dmack}, 32'h0);
    csr_read(3'd3, v);
    check(v[0] == 1'b0, "R8 not done during pause", v, 32'h0);
    dmarq = 1'b1;
    wait_done(ok);
    check(ok && (mw_cnt - start) == 6, "R8 full count after resume", mw_cnt - start, 32'd6);
    csr_write(3'd3, 32'h1);

    // R9 stop on request drop
    cur_tag = "R9";
    csr_write(3'd1, 32'hA0);
    push_reads(8, 16'hA0, rd_idx, 1'b0);
    start = mw_cnt;
    csr_write(3'd0, cfg_word(1, 0, 1, 0, 20'd7));
    while (mw_cnt < start + 3) @(negedge clk);
    dmarq = 1'b0;
    wait_done(ok);
    k = mw_cnt - start;
    check(ok && k >= 3 && k < 8, "R9 transfer ended early", k, 32'd3);
    csr_read(3'd0, v);
    check(v == cfg_word(0, 0, 1, 0, 20'(8 - k - 1)), "R9 residual size", v, cfg_word(0, 0, 1, 0, 20'(8 - k - 1)));
    mq.delete();
    csr_write(3'd3, 32'h1);

    // R10 read strobe width with 4x multiplier
    cur_tag = "R10";
    csr_write(3'd2, tim_word(2'd0, 4'd1, 4'd0, 4'd0, 4'd0, 3'd0, 3'd0, 4'd0, 4'd0));
    csr_write(3'd1, 32'hC0);
    push_reads(1, 16'hC0, rd_idx, 1'b0);
    dmarq = 1'b1;
    csr_write(3'd0, cfg_word(1, 0, 0, 0, 20'd0));
    wait_done(ok);
    check(ok && last_rw == 8, "R10 read strobe width 4x", last_rw, 32'd8);
    csr_write(3'd3, 32'h1);

    // R11 request qualification is unscaled and enforced
    cur_tag = "R11";
    dmarq = 1'b0;
    csr_write(3'd2, tim_word(2'd1, 4'd0, 4'd0, 4'd0, 4'd0, 3'd0, 3'd0, 4'd0, 4'd15));
    csr_write(3'd1, 32'hD0);
    push_reads(1, 16'hD0, rd_idx, 1'b0);
    csr_write(3'd0, cfg_word(1, 0, 0, 0, 20'd0));
    repeat (5) @(negedge clk);
    dmarq = 1'b1;
    dly = 0;
    while (dior_n && dly < 500) begin @(negedge clk); dly++; end
    check(dly >= 17 && dly < 40, "R11 strobe waits for qualified request", dly, 32'd18);
    wait_done(ok);
    csr_write(3'd3, 32'h1);

    // R12 abort in the middle of a long strobe, R13 acknowledge during it
    cur_tag = "R12";
    csr_write(3'd2, tim_word(2'd3, 4'd15, 4'd0, 4'd0, 4'd0, 3'd0, 3'd0, 4'd0, 4'd0));
    csr_write(3'd0, cfg_word(1, 0, 0, 0, 20'd4));
    dly = 0;
    while (dior_n && dly < 500) begin @(negedge clk); dly++; end
    check(dmack == 1'b1, "R13 acknowledge high during strobe", {31'h0, dmack}, 32'h1);
    csr_write(3'd0, cfg_word(0, 0, 0, 0, 20'hFFFFF));
    repeat (3) @(negedge clk);
    check(dior_n && diow_n && !dmack, "R12 pins idle after stop", {29'h0, dior_n, diow_n, dmack}, 32'h6);
    csr_read(3'd3, v);
    check(v[0] == 1'b0, "R12 stop leaves done clear", v, 32'h0);
    csr_read(3'd0, v);
    check(v == 32'h00FFFFF0, "R12 config idle after stop", v, 32'h00FFFFF0);
    repeat (20) @(negedge clk);
    check(mq.size() == 0 && dq.size() == 0, "R2 scoreboard drained", mq.size() + dq.size(), 32'h0);

    finish_run();
  end

endmodule